// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of 32-bit registers to or from memory in one operation. The register file has sixteen entries: eight data registers (indices 0 to 7, D0 to D7) and eight address registers (indices 8 to 15, A0 to A7). The controlling pipeline supplies the operation on a `start` pulse. It gives the transfer size, the direction, the addressing mode and its sub-field, the base address register, the effective address already computed, and a 16-bit select mask. The sequencer then makes one request/acknowledge memory access for each selected register, in a fixed order.

The mask is read in two ways. In the predecrement store form the bits are reversed, so the address registers come first and the address steps down before each write. In every other form, bit k names register k and the address steps up after each access. When the list is finished, the block writes the final address back to the base register if the mode requires it. It then pulses `done` and shows the cycle cost of the operation on `cost`. The register file stays outside the block and is reached through one combinational read port and one write port.

Top module: `regblk_xfer`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `rf_we` are all low.
- R2: Exactly one accepted memory access (`mem_req` and `mem_ack` high together) takes place for each set mask bit. A request that is not yet acknowledged keeps `mem_req` high and holds `mem_addr` and `mem_we` steady until the acknowledge.
- R3: For loads (`to_mem`=0), and for stores in any mode other than 4, mask bit k selects register index k (0-7 = D0-D7, 8-15 = A0-A7). Bits are served from bit 0 upward. The first address is `start_addr`, and the address rises by the step after each access.
- R4: For stores in mode 4 (predecrement), mask bit k selects register index 15-k, so bit 0 is A7 and bit 15 is D0. Bits are served from bit 0 upward, and the address falls by the step before each write, so the first write goes to `start_addr` minus the step.
- R5: `xfer_wide`=0 gives a 2-byte step, and a store then drives the low 16 bits of the register on `mem_wdata[15:0]` with zeros above them. `xfer_wide`=1 gives a 4-byte step and a full 32-bit store.
- R6: A load writes the register file in the cycle of the acknowledge. In 16-bit mode the value written is `mem_rdata[15:0]` sign-extended from bit 15, for data and address registers alike.
- R7: In the `done` cycle the block writes the final address into register 8+`base_reg`, but only for stores in mode 4 and loads in mode 3. No other operation writes the register file in its `done` cycle.
- R8: While `done` is high, `cost` equals the number of selected registers times 4 (16-bit) or 8 (32-bit), plus a mode overhead. For stores the overhead is 8 for modes 2-4, 12 for mode 5, 14 for mode 6, 12 for mode 7/sub 0 and 16 for mode 7/sub 1. For loads it is 12 for modes 2-4, 16 for mode 5, 18 for mode 6, and 16/20/16/18 for mode 7/sub 0/1/2/3. Every other case has an overhead of 0.
- R9: An all-zero mask makes no memory request. `done` rises in the cycle after the start, and `cost` equals the mode overhead alone.
- R10: `done` is high for exactly one cycle and `busy` falls right after it. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| xfer_wide | input | 1 | 0 = 16-bit items, 1 = 32-bit items |
| to_mem | input | 1 | 1 = registers to memory, 0 = memory to registers |
| ea_mode | input | 3 | Addressing mode number |
| ea_sub | input | 3 | Mode 7 sub-field (0 abs short, 1 abs long, 2 PC+disp, 3 PC+index) |
| base_reg | input | 3 | Address register used as base |
| start_addr | input | 32 | Starting effective address |
| sel_mask | input | 16 | Register select mask |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Request is 32-bit |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Single-cycle completion pulse |
| cost | output | 8 | Cycle cost of the finished operation |

## Verification
The assertions assume that the memory side only raises `mem_ack` while `mem_req` is high. They also assume that `mem_rdata` is valid in the acknowledge cycle and that the register file read is combinational and stable within a cycle. The stimulus meets these conditions: the bench memory raises an acknowledge only after it has seen a request at a falling edge, then drops it after one cycle, and the register file model changes only at a clock edge on `rf_we`. The stimulus keeps the base register out of the mask for load postincrement, so a loaded value and the writeback never compete for the same register. It also uses only 16 and 32 bit sizes.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } rbx_state_e;

  // Fixed overhead charged by addressing mode, per direction.
  function automatic int unsigned mode_overhead(input logic to_mem,
                                                input logic [2:0] mode,
                                                input logic [2:0] sub);
    int unsigned ov;
    ov = 0;
    if (to_mem) begin
      case (mode)
        3'd2, 3'd3, 3'd4: ov = 8;
        3'd5:             ov = 12;
        3'd6:             ov = 14;
        3'd7:             ov = (sub == 3'd0) ? 12 : (sub == 3'd1) ? 16 : 0;
        default:          ov = 0;
      endcase
    end else begin
      case (mode)
        3'd2, 3'd3, 3'd4: ov = 12;
        3'd5:             ov = 16;
        3'd6:             ov = 18;
        3'd7: begin
          case (sub)
            3'd0, 3'd2: ov = 16;
            3'd1:       ov = 20;
            3'd3:       ov = 18;
            default:    ov = 0;
          endcase
        end
        default:          ov = 0;
      endcase
    end
    return ov;
  endfunction

  // Cost of one moved item.
  function automatic int unsigned item_cost(input logic wide);
    return wide ? 8 : 4;
  endfunction

  // Address step of one item in bytes.
  function automatic int unsigned item_step(input logic wide);
    return wide ? 4 : 2;
  endfunction

endpackage

// File: rtl/rbx_scan.sv
module rbx_scan #(
  parameter int MASK_W = 16,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MASK_W-1:0] mask_in,
  input  logic              consume,
  input  logic              reverse,
  output logic              pend_last,
  output logic [IDX_W-1:0]  cur_idx
);

  logic [MASK_W-1:0] pend;
  logic [IDX_W-1:0]  pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= '0;
    else if (load)    pend <= mask_in;
    else if (consume) pend <= pend & ~(MASK_W'(1) << pick);
  end

  // lowest pending bit: the loop runs downward so the smallest index wins
  always_comb begin
    pick = '0;
    for (int k = MASK_W - 1; k >= 0; k--) begin
      if (pend[k]) pick = IDX_W'(k);
    end
  end

  assign pend_last = ((pend & (pend - MASK_W'(1))) == '0);
  assign cur_idx   = reverse ? IDX_W'(MASK_W - 1) - pick : pick;

endmodule

// File: rtl/rbx_addr.sv
module rbx_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              advance,
  input  logic              wide,
  input  logic              down,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] beat_addr
);
  import rbx_pkg::*;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_q;

  assign step = ADDR_W'(item_step(wide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (load)    addr_q <= addr_in;
    else if (advance) addr_q <= down ? addr_q - step : addr_q + step;
  end

  assign cur_addr  = addr_q;
  assign beat_addr = down ? addr_q - step : addr_q;

endmodule

// File: rtl/rbx_cost.sv
module rbx_cost #(
  parameter int MASK_W = 16,
  parameter int COST_W = 8
) (
  input  logic              wide,
  input  logic              to_mem,
  input  logic [2:0]        mode,
  input  logic [2:0]        sub,
  input  logic [MASK_W-1:0] mask,
  output logic [COST_W-1:0] cost
);
  import rbx_pkg::*;

  int unsigned n_sel;

  always_comb begin
    n_sel = $countones(mask);
    cost  = COST_W'(n_sel * item_cost(wide) + mode_overhead(to_mem, mode, sub));
  end

endmodule

// File: rtl/regblk_xfer.sv
module regblk_xfer #(
  parameter int HALF_REGS = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int COST_W    = 8,
  localparam int MASK_W   = 2 * HALF_REGS,
  localparam int IDX_W    = $clog2(MASK_W),
  localparam int BASE_W   = $clog2(HALF_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              xfer_wide,
  input  logic              to_mem,
  input  logic [2:0]        ea_mode,
  input  logic [2:0]        ea_sub,
  input  logic [BASE_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [MASK_W-1:0] sel_mask,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost
);
  import rbx_pkg::*;

  rbx_state_e        state;
  logic              wide_q, to_mem_q, predec_q, wb_q;
  logic [BASE_W-1:0] base_q;
  logic [COST_W-1:0] cost_q;

  // named internal events
  logic              start_ok;   // start taken in idle
  logic              acc_fire;   // memory beat accepted
  logic              pend_last;  // current beat is the last one
  logic              wb_fire;    // base register writeback
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_addr, beat_addr;
  logic [COST_W-1:0] cost_next;
  logic [DATA_W-1:0] load_val;

  assign start_ok = start && (state == ST_IDLE);
  assign acc_fire = (state == ST_XFER) && mem_ack;
  assign wb_fire  = (state == ST_FIN) && wb_q;

  rbx_scan #(.MASK_W(MASK_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .mask_in   (sel_mask),
    .consume   (acc_fire),
    .reverse   (predec_q),
    .pend_last (pend_last),
    .cur_idx   (cur_idx)
  );

  rbx_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .addr_in   (start_addr),
    .advance   (acc_fire),
    .wide      (wide_q),
    .down      (predec_q),
    .cur_addr  (cur_addr),
    .beat_addr (beat_addr)
  );

  rbx_cost #(.MASK_W(MASK_W), .COST_W(COST_W)) u_cost (
    .wide   (xfer_wide),
    .to_mem (to_mem),
    .mode   (ea_mode),
    .sub    (ea_sub),
    .mask   (sel_mask),
    .cost   (cost_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wide_q   <= 1'b0;
      to_mem_q <= 1'b0;
      predec_q <= 1'b0;
      wb_q     <= 1'b0;
      base_q   <= '0;
      cost_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            wide_q   <= xfer_wide;
            to_mem_q <= to_mem;
            predec_q <= to_mem && (ea_mode == 3'd4);
            wb_q     <= (to_mem && (ea_mode == 3'd4)) || (!to_mem && (ea_mode == 3'd3));
            base_q   <= base_reg;
            cost_q   <= cost_next;
            state    <= (sel_mask == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: if (acc_fire && pend_last) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_val = wide_q ? mem_rdata
                           : {{(DATA_W-16){mem_rdata[15]}}, mem_rdata[15:0]};

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign cost      = cost_q;
  assign mem_req   = (state == ST_XFER);
  assign mem_we    = to_mem_q;
  assign mem_wide  = wide_q;
  assign mem_addr  = beat_addr;
  assign rf_rd_idx = cur_idx;
  assign mem_wdata = wide_q ? rf_rd_data : {{(DATA_W-16){1'b0}}, rf_rd_data[15:0]};

  always_comb begin
    rf_we      = 1'b0;
    rf_wr_idx  = cur_idx;
    rf_wr_data = load_val;
    if (acc_fire && !to_mem_q) begin
      rf_we = 1'b1;
    end else if (wb_fire) begin
      rf_we      = 1'b1;
      rf_wr_idx  = {1'b1, base_q};
      rf_wr_data = DATA_W'(cur_addr);
    end
  end

endmodule

// File: rtl/rbx_chk.sv
module rbx_chk #(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [MASK_W-1:0] sel_mask,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rf_we,
  input logic              acc_fire,
  input logic              wide_q,
  input logic              down_q
);

  logic [ADDR_W-1:0] step_w;
  assign step_w = wide_q ? ADDR_W'(4) : ADDR_W'(2);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R3 R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (!mem_req || (down_q ? (mem_addr == $past(mem_addr) - step_w)
                                      : (mem_addr == $past(mem_addr) + step_w))));

  // R6 R7
  rf_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((acc_fire && !mem_we) || done));

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (sel_mask == '0)) |=> (done && !mem_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind regblk_xfer rbx_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .sel_mask (sel_mask),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .rf_we    (rf_we),
  .acc_fire (acc_fire),
  .wide_q   (wide_q),
  .down_q   (predec_q)
);

// File: tb/tb_regblk_xfer.sv
module tb_regblk_xfer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        xfer_wide = 1'b0;
  logic        to_mem = 1'b0;
  logic [2:0]  ea_mode = 3'd0;
  logic [2:0]  ea_sub = 3'd0;
  logic [2:0]  base_reg = 3'd0;
  logic [31:0] start_addr = '0;
  logic [15:0] sel_mask = '0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_we;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;
  logic [7:0]  cost;

  always #2 clk = ~clk;

  regblk_xfer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_wide(xfer_wide),
    .to_mem(to_mem), .ea_mode(ea_mode), .ea_sub(ea_sub), .base_reg(base_reg),
    .start_addr(start_addr), .sel_mask(sel_mask),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cost(cost)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } beat_t;

  beat_t       exp_q[$];
  logic [31:0] rf[16];
  logic [31:0] model[16];
  int          checks = 0;
  int          errors = 0;
  int          ack_dly = 0;
  int          wait_cnt = 0;
  bit          finished = 0;

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) if (rf_we) rf[rf_wr_idx] <= rf_wr_data;

  function automatic logic [31:0] data_at(input logic [31:0] a);
    logic [15:0] lo;
    lo = a[4] ? (16'hF000 | {4'h0, a[11:0]}) : {4'h0, a[11:0]};
    return {a[15:0] ^ 16'h5A5A, lo};
  endfunction

  function automatic int ovh_ref(input logic tm, input logic [2:0] md, input logic [2:0] sb);
    if (md >= 3'd2 && md <= 3'd4) return tm ? 8 : 12;
    if (md == 3'd5) return tm ? 12 : 16;
    if (md == 3'd6) return tm ? 14 : 18;
    if (md == 3'd7) begin
      if (tm) return (sb == 0) ? 12 : (sb == 1) ? 16 : 0;
      if (sb == 1) return 20;
      if (sb == 3) return 18;
      if (sb == 0 || sb == 2) return 16;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_req && rst_n) begin
      if (wait_cnt >= ack_dly) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected access addr", mem_addr, 32'h0);
        end else begin
          beat_t b;
          b = exp_q.pop_front();
          chk(mem_addr == b.addr, "R3/R4", "beat address", mem_addr, b.addr);
          chk(mem_we == b.we, "R2", "beat direction", {31'b0, mem_we}, {31'b0, b.we});
          if (b.we) chk(mem_wdata == b.wdata, "R5", "store data", mem_wdata, b.wdata);
        end
        mem_rdata = data_at(mem_addr);
        mem_ack = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic run_op(input logic w, input logic tm, input logic [2:0] md,
                        input logic [2:0] sb, input logic [2:0] bs,
                        input logic [31:0] a0, input logic [15:0] msk,
                        input int dly, input bit poke);
    logic [31:0] a;
    logic [31:0] v;
    int stp;
    int n;
    int exp_cost;
    bit down;
    a = a0;
    stp = w ? 4 : 2;
    n = 0;
    down = tm && (md == 3'd4);
    for (int k = 0; k < 16; k++) begin
      if (msk[k]) begin
        int r;
        beat_t b;
        r = down ? 15 - k : k;          // R4 reversed mapping, R3 direct
        if (down) a = a - stp;
        b.we = tm;
        b.addr = a;
        b.wdata = w ? model[r] : {16'h0, model[r][15:0]};
        exp_q.push_back(b);
        if (!tm) begin
          v = data_at(a);
          model[r] = w ? v : {{16{v[15]}}, v[15:0]};   // R6
        end
        if (!down) a = a + stp;
        n++;
      end
    end
    if ((tm && md == 3'd4) || (!tm && md == 3'd3)) model[8 + bs] = a;   // R7
    exp_cost = n * (w ? 8 : 4) + ovh_ref(tm, md, sb);                  // R8
    ack_dly = dly;

    @(negedge clk);
    xfer_wide = w; to_mem = tm; ea_mode = md; ea_sub = sb; base_reg = bs;
    start_addr = a0; sel_mask = msk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (msk == 16'h0)
      chk(done === 1'b1, "R9", "done one cycle after start", {31'b0, done}, 32'h1);
    if (poke && !done) begin
      sel_mask = 16'hFFFF; start = 1'b1;   // R10 start while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(cost == exp_cost[7:0], (msk == 0) ? "R9" : "R8", "cost", {24'h0, cost}, exp_cost);
    chk(exp_q.size() == 0, "R2", "beats left over", exp_q.size(), 32'h0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done pulse / busy drop",
        {30'b0, done, busy}, 32'h0);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R10", "no activity after done", {31'b0, mem_req}, 32'h0);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == model[i], "R6/R7", $sformatf("register %0d", i), rf[i], model[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'hA000_0000 | (32'(i) << 16) | (32'h1234 + 32'(i) * 32'h1111);
      model[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && mem_req == 0 && rf_we == 0, "R1", "reset outputs",
        {28'h0, busy, done, mem_req, rf_we}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5 32-bit store, indirect mode, no writeback
    run_op(1, 1, 3'd2, 3'd0, 3'd1, 32'h0000_1000, 16'h8103, 0, 0);
    // R4 R5 R7 16-bit predecrement store with base A6 writeback
    run_op(0, 1, 3'd4, 3'd0, 3'd6, 32'h0000_2000, 16'hC0A1, 1, 0);
    // R4 32-bit predecrement store, full mask including the base A7
    run_op(1, 1, 3'd4, 3'd0, 3'd7, 32'h0000_2800, 16'hFFFF, 0, 0);
    // R6 R7 16-bit postincrement load, base A2 kept out of the mask
    run_op(0, 0, 3'd3, 3'd0, 3'd2, 32'h0000_3000, 16'h30C3, 0, 0);
    // R3 R6 32-bit load of all registers, displacement mode, slow memory
    run_op(1, 0, 3'd5, 3'd0, 3'd0, 32'h0000_4000, 16'hFFFF, 2, 0);
    // R8 16-bit load with PC-index overhead
    run_op(0, 0, 3'd7, 3'd3, 3'd0, 32'h0000_5010, 16'h0400, 0, 0);
    // R10 start while busy is ignored; absolute long store
    run_op(1, 1, 3'd7, 3'd1, 3'd0, 32'h0000_6000, 16'h0011, 3, 1);
    // R9 empty masks
    run_op(0, 1, 3'd4, 3'd0, 3'd3, 32'h0000_7000, 16'h0000, 0, 0);
    run_op(1, 0, 3'd6, 3'd0, 3'd0, 32'h0000_7100, 16'h0000, 0, 0);
    // R8 unlisted mode gives zero overhead
    run_op(0, 0, 3'd0, 3'd0, 3'd0, 32'h0000_7200, 16'h0100, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule